// File: doc/BRIEF.md
# Token Transmit Sequencer

This block runs the transmit side of a node on a token-passing network. Software loads one message at a time with a transmit command that names a destination node and says whether the message is broadcast. The message then waits until the node is given the token. At that point the block does one of two things. For a directed message, it first asks the destination whether it has a free buffer. For a broadcast message, it sends the data straight away.

After an enquiry, the block waits for the reply from an external response decoder. The reply may be an acknowledge, a refusal, line noise, or silence. Each reply leads to a different action: the block sends the data frame, hands the token on, halts in place, or gives up. Two status bits report progress. The transmitter-available bit is high when no message is pending. The transmit-acknowledged bit shows that the last message was confirmed by its receiver.

A counter tracks refusals that follow one another. When it reaches a limit set by software, it raises an excessive-refusal flag, which can also drive an interrupt. Software can then cancel the message with a disable command. The cancellation only takes effect the next time the token arrives.

Top module: `tokenTxSequencer`

## Requirements
- R1: After reset, txAvail is 1, txAcked is 0, excNak is 0, irq is 0, and sendFbe, sendData and passToken are all 0.
- R2: A cmdXmit pulse while txAvail is 1 does four things: it clears txAvail and txAcked, latches cmdDest and cmdBcast, and clears the refusal count. A cmdXmit pulse while txAvail is 0 is ignored, so frameDest keeps the first destination.
- R3: If txAvail is 1 when a token pulse arrives, passToken pulses in the next cycle and no frame request is raised.
- R4: If a directed message is pending and no cancel is armed when a token pulse arrives, sendFbe pulses in the next cycle. frameDest then holds the latched destination.
- R5: An ackIn pulse that answers the enquiry gives a sendData pulse in the next cycle. A second ackIn pulse, answering the data frame, sets txAvail and txAcked to 1 and pulses passToken in the next cycle.
- R6: After the data frame has been sent, a nakIn or noiseIn pulse fails the message. So does RESP_WAIT cycles with no reply at all. A failure sets txAvail to 1, leaves txAcked at 0, and pulses passToken.
- R7: If a broadcast message is pending when a token pulse arrives, sendData and passToken pulse together in the next cycle. txAvail becomes 1, txAcked stays 0, and no enquiry is sent.
- R8: A nakIn pulse that answers the enquiry pulses passToken and adds one to the refusal count. The message stays pending (txAvail stays 0), and the next token pulse sends the enquiry again.
- R9: If no reply arrives after an enquiry, the block sets txAvail to 1, leaves txAcked at 0, and pulses passToken. This happens exactly RESP_WAIT cycles after the sendFbe pulse, and nothing changes before that.
- R10: A noiseIn pulse that answers the enquiry does not pulse passToken and leaves txAvail and txAcked unchanged. The message stays pending, and the next token pulse sends the enquiry again.
- R11: excNak is 1 when nakLimit is nonzero and the refusal count is at least nakLimit. It becomes 1 in the cycle after the refusal that reaches the limit. The count saturates at its maximum, and it clears on any enquiry outcome other than a refusal and on an accepted cmdXmit.
- R12: irq is 1 exactly when excNak and irqEnable are both 1.
- R13: A cmdDisable pulse while txAvail is 0 arms a cancel. At the next token pulse, the block sets txAvail to 1, leaves txAcked at 0, pulses passToken and sends no frame. A cmdDisable pulse while txAvail is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokenIn | input | 1 | One-cycle pulse: the token has arrived at this node |
| ackIn | input | 1 | One-cycle pulse: an acknowledge was decoded |
| nakIn | input | 1 | One-cycle pulse: a refusal was decoded |
| noiseIn | input | 1 | One-cycle pulse: an unrecognised reply was decoded |
| cmdXmit | input | 1 | One-cycle pulse: transmit command |
| cmdDest | input | DEST_W | Destination node ID for the transmit command |
| cmdBcast | input | 1 | The transmit command is a broadcast |
| cmdDisable | input | 1 | One-cycle pulse: cancel the pending message |
| nakLimit | input | CNT_W | Refusal count that raises excNak (0 turns the flag off; 128 is typical) |
| irqEnable | input | 1 | Interrupt mask for excNak |
| sendFbe | output | 1 | Pulse: send a free-buffer enquiry to frameDest |
| sendData | output | 1 | Pulse: send the data frame |
| frameDest | output | DEST_W | Latched destination ID |
| passToken | output | 1 | Pulse: pass the token to the next node |
| txAvail | output | 1 | Transmitter available (no message pending) |
| txAcked | output | 1 | Last message was acknowledged |
| excNak | output | 1 | Excessive-refusal flag |
| irq | output | 1 | Masked excessive-refusal interrupt |

## Verification
The bench sweeps the refusal limit from 1 to 4 with the interrupt mask both set and clear. A design whose count or comparison is off by one would raise excNak one round early or late, and a design that failed to clear the count would keep the flag high after an acknowledge. The reply window is probed on the cycle before and the cycle of expiry, in both the enquiry phase and the data phase, so a timer that is off by one cycle is caught. Noise is checked for two things: that no token is passed, and that the enquiry is sent again at the next token. Cancels are checked for deferral to the next token and for being ignored when nothing is pending. A second transmit command is checked for being unable to overwrite the destination of a message that is already pending.

// File: rtl/tokenTxPkg.sv
package tokenTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_ENQ  = 2'd1,
    ST_WAIT_DATA = 2'd2
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic armCancel;
    logic sendFbe;
    logic sendData;
    logic passTok;
    logic doneOk;
    logic doneFail;
    logic nakInc;
    logic nakClr;
    logic timerClr;
  } txStrobes_t;

endpackage

// File: rtl/tokenTxDatapath.sv
module tokenTxDatapath
  import tokenTxPkg::*;
#(
  parameter int DEST_W    = 8,
  parameter int CNT_W     = 8,
  parameter int RESP_WAIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        stb,
  input  logic [DEST_W-1:0] cmdDest,
  input  logic              cmdBcast,
  input  logic [CNT_W-1:0]  nakLimit,
  input  logic              irqEnable,
  output logic              txAvail,
  output logic              txAcked,
  output logic              isBcast,
  output logic              cancelArmed,
  output logic              respTimeout,
  output logic [DEST_W-1:0] frameDest,
  output logic              sendFbe,
  output logic              sendData,
  output logic              passToken,
  output logic              excNak,
  output logic              irq
);

  localparam int TMR_W = (RESP_WAIT > 2) ? $clog2(RESP_WAIT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RESP_WAIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TMR_W-1:0] waitTimer;
  logic [CNT_W-1:0] nakCount;

  // status bits and latched command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txAvail     <= 1'b1;
      txAcked     <= 1'b0;
      isBcast     <= 1'b0;
      frameDest   <= '0;
      cancelArmed <= 1'b0;
    end else begin
      if (stb.latchCmd) begin
        txAvail   <= 1'b0;
        txAcked   <= 1'b0;
        isBcast   <= cmdBcast;
        frameDest <= cmdDest;
      end
      if (stb.doneOk || stb.doneFail) txAvail <= 1'b1;
      if (stb.doneOk) txAcked <= 1'b1;
      if (stb.armCancel) cancelArmed <= 1'b1;
      if (stb.latchCmd || stb.doneOk || stb.doneFail) cancelArmed <= 1'b0;
    end
  end

  // reply window timer, saturating at the last cycle
  always_ff @(posedge clk) begin
    if (!rstN || stb.timerClr) waitTimer <= '0;
    else if (waitTimer != TMR_LAST) waitTimer <= waitTimer + 1'b1;
  end
  assign respTimeout = (waitTimer == TMR_LAST);

  // refusal counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.nakClr) nakCount <= '0;
    else if (stb.nakInc && nakCount != CNT_MAX) nakCount <= nakCount + 1'b1;
  end
  assign excNak = (nakLimit != '0) && (nakCount >= nakLimit);
  assign irq    = excNak && irqEnable;

  // registered request pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendFbe   <= 1'b0;
      sendData  <= 1'b0;
      passToken <= 1'b0;
    end else begin
      sendFbe   <= stb.sendFbe;
      sendData  <= stb.sendData;
      passToken <= stb.passTok;
    end
  end

  a_r5_acked_implies_avail: assert property (@(posedge clk) disable iff (!rstN)
    txAcked |-> txAvail);
  a_r2_dest_held: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchCmd == 1'b0) |=> $stable(frameDest));
  a_r4_enquiry_only_pending: assert property (@(posedge clk) disable iff (!rstN)
    sendFbe |-> !txAvail);
  a_r11_clear_drops_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.nakClr |=> !excNak);
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (excNak && irqEnable));

endmodule

// File: rtl/tokenTxControl.sv
module tokenTxControl
  import tokenTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokenIn,
  input  logic       ackIn,
  input  logic       nakIn,
  input  logic       noiseIn,
  input  logic       cmdXmit,
  input  logic       cmdDisable,
  input  logic       txAvail,
  input  logic       isBcast,
  input  logic       cancelArmed,
  input  logic       respTimeout,
  output txStrobes_t stb
);

  txState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    if (cmdXmit && txAvail) begin
      stb.latchCmd = 1'b1;
      stb.nakClr   = 1'b1;
    end
    if (cmdDisable && !txAvail) stb.armCancel = 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (tokenIn) begin
          if (txAvail) begin
            stb.passTok = 1'b1;
          end else if (cancelArmed) begin
            stb.doneFail = 1'b1;
            stb.passTok  = 1'b1;
          end else if (isBcast) begin
            stb.sendData = 1'b1;
            stb.doneFail = 1'b1;
            stb.passTok  = 1'b1;
          end else begin
            stb.sendFbe  = 1'b1;
            stb.timerClr = 1'b1;
            nextState    = ST_WAIT_ENQ;
          end
        end
      end
      ST_WAIT_ENQ: begin
        if (ackIn) begin
          stb.sendData = 1'b1;
          stb.timerClr = 1'b1;
          stb.nakClr   = 1'b1;
          nextState    = ST_WAIT_DATA;
        end else if (nakIn) begin
          stb.passTok = 1'b1;
          stb.nakInc  = 1'b1;
          nextState   = ST_IDLE;
        end else if (noiseIn) begin
          stb.nakClr = 1'b1;
          nextState  = ST_IDLE;
        end else if (respTimeout) begin
          stb.doneFail = 1'b1;
          stb.passTok  = 1'b1;
          stb.nakClr   = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_WAIT_DATA: begin
        if (ackIn) begin
          stb.doneOk  = 1'b1;
          stb.passTok = 1'b1;
          nextState   = ST_IDLE;
        end else if (nakIn || noiseIn || respTimeout) begin
          stb.doneFail = 1'b1;
          stb.passTok  = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  a_r8_nak_keeps_pending: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_ENQ && nakIn && !ackIn) |=> !txAvail);
  a_r10_noise_holds_state: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_ENQ && noiseIn && !ackIn && !nakIn) |=> (!txAvail && state == ST_IDLE));
  a_r3_wait_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !txAvail);

endmodule

// File: rtl/tokenTxSequencer.sv
module tokenTxSequencer
  import tokenTxPkg::*;
#(
  parameter int DEST_W    = 8,
  parameter int CNT_W     = 8,
  parameter int RESP_WAIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokenIn,
  input  logic              ackIn,
  input  logic              nakIn,
  input  logic              noiseIn,
  input  logic              cmdXmit,
  input  logic [DEST_W-1:0] cmdDest,
  input  logic              cmdBcast,
  input  logic              cmdDisable,
  input  logic [CNT_W-1:0]  nakLimit,
  input  logic              irqEnable,
  output logic              sendFbe,
  output logic              sendData,
  output logic [DEST_W-1:0] frameDest,
  output logic              passToken,
  output logic              txAvail,
  output logic              txAcked,
  output logic              excNak,
  output logic              irq
);

  txStrobes_t stb;
  logic isBcast, cancelArmed, respTimeout;

  tokenTxControl ctrl (
    .clk, .rstN, .tokenIn, .ackIn, .nakIn, .noiseIn, .cmdXmit, .cmdDisable,
    .txAvail, .isBcast, .cancelArmed, .respTimeout, .stb
  );

  tokenTxDatapath #(.DEST_W(DEST_W), .CNT_W(CNT_W), .RESP_WAIT(RESP_WAIT)) dp (
    .clk, .rstN, .stb, .cmdDest, .cmdBcast, .nakLimit, .irqEnable,
    .txAvail, .txAcked, .isBcast, .cancelArmed, .respTimeout, .frameDest,
    .sendFbe, .sendData, .passToken, .excNak, .irq
  );

  a_r7_one_frame_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sendFbe, sendData}));

endmodule

// File: tb/tokenTxSequencer_test.sv
module tokenTxSequencer_test;

  localparam int WAIT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokenIn = 0, ackIn = 0, nakIn = 0, noiseIn = 0, cmdXmit = 0, cmdBcast = 0, cmdDisable = 0;
  logic irqEnable = 0;
  logic [7:0] cmdDest = 0, nakLimit = 8'd3;
  logic sendFbe, sendData, passToken, txAvail, txAcked, excNak, irq;
  logic [7:0] frameDest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tokenTxSequencer #(.DEST_W(8), .CNT_W(8), .RESP_WAIT(WAIT)) uut (
    .clk, .rstN, .tokenIn, .ackIn, .nakIn, .noiseIn, .cmdXmit, .cmdDest, .cmdBcast,
    .cmdDisable, .nakLimit, .irqEnable, .sendFbe, .sendData, .frameDest, .passToken,
    .txAvail, .txAcked, .excNak, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle with the given pulses; returns at the sampling point
  task automatic step(input bit tok, input bit a, input bit n, input bit nz);
    tokenIn = tok; ackIn = a; nakIn = n; noiseIn = nz;
    @(negedge clk);
    tokenIn = 0; ackIn = 0; nakIn = 0; noiseIn = 0;
  endtask

  task automatic xmit(input logic [7:0] d, input bit b);
    cmdXmit = 1; cmdDest = d; cmdBcast = b;
    @(negedge clk);
    cmdXmit = 0; cmdBcast = 0;
  endtask

  task automatic outs(input string req, input bit f, input bit d, input bit p);
    chk({req, " sendFbe"}, sendFbe, f);
    chk({req, " sendData"}, sendData, d);
    chk({req, " passToken"}, passToken, p);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txAvail", txAvail, 1); chk("R1 txAcked", txAcked, 0);
    chk("R1 excNak", excNak, 0); chk("R1 irq", irq, 0);
    outs("R1", 0, 0, 0);

    // R3 token with nothing pending
    step(1, 0, 0, 0); outs("R3", 0, 0, 1);
    step(0, 0, 0, 0); outs("R3 after", 0, 0, 0);

    // R2 accepted command, R4 enquiry, R5 full success
    xmit(8'h5A, 0);
    chk("R2 txAvail", txAvail, 0); chk("R2 txAcked", txAcked, 0);
    xmit(8'hC3, 0); // ignored while pending
    chk("R2 dest kept", frameDest, 8'h5A);
    step(1, 0, 0, 0); outs("R4", 1, 0, 0); chk("R4 frameDest", frameDest, 8'h5A);
    step(0, 1, 0, 0); outs("R5 data", 0, 1, 0);
    step(0, 1, 0, 0); outs("R5 done", 0, 0, 1);
    chk("R5 txAvail", txAvail, 1); chk("R5 txAcked", txAcked, 1);

    // R7 broadcast
    xmit(8'h00, 1);
    chk("R2 txAcked cleared", txAcked, 0);
    step(1, 0, 0, 0); outs("R7", 0, 1, 1);
    chk("R7 txAvail", txAvail, 1); chk("R7 txAcked", txAcked, 0);

    // R8/R11/R12 refusal sweep over limits and mask
    for (int lim = 1; lim <= 4; lim++) begin
      for (int en = 0; en <= 1; en++) begin
        nakLimit = 8'(lim); irqEnable = en[0];
        xmit(8'(16 * lim + en), 0);
        chk("R11 cleared by command", excNak, 0);
        for (int i = 1; i <= lim + 1; i++) begin
          step(1, 0, 0, 0); outs("R8 enquiry", 1, 0, 0);
          step(0, 0, 1, 0); outs("R8 refusal", 0, 0, 1);
          chk("R8 still pending", txAvail, 0);
          chk("R11 excNak", excNak, (i >= lim));
          chk("R12 irq", irq, (i >= lim) && en);
        end
        step(1, 0, 0, 0); outs("R8 reissue", 1, 0, 0);
        step(0, 1, 0, 0); outs("R5 data", 0, 1, 0);
        chk("R11 cleared by ack", excNak, 0); chk("R12 irq low", irq, 0);
        step(0, 1, 0, 0); outs("R5 done", 0, 0, 1);
      end
    end
    // limit 0 disables the flag
    nakLimit = 0;
    xmit(8'h11, 0);
    step(1, 0, 0, 0); step(0, 0, 1, 0);
    chk("R11 limit zero", excNak, 0);
    nakLimit = 8'd3;

    // R9 enquiry timeout (pending from above)
    step(1, 0, 0, 0); outs("R9 enquiry", 1, 0, 0);
    for (int j = 1; j <= WAIT; j++) begin
      step(0, 0, 0, 0);
      chk("R9 passToken", passToken, (j == WAIT));
      chk("R9 txAvail", txAvail, (j == WAIT));
    end
    chk("R9 txAcked", txAcked, 0);

    // R6 data-phase silence
    xmit(8'h22, 0);
    step(1, 0, 0, 0); step(0, 1, 0, 0); outs("R6 data", 0, 1, 0);
    for (int j = 1; j <= WAIT; j++) begin
      step(0, 0, 0, 0);
      chk("R6 passToken", passToken, (j == WAIT));
      chk("R6 txAvail", txAvail, (j == WAIT));
    end
    chk("R6 txAcked", txAcked, 0);
    // R6 data-phase refusal and noise
    xmit(8'h23, 0);
    step(1, 0, 0, 0); step(0, 1, 0, 0);
    step(0, 0, 1, 0); outs("R6 nak", 0, 0, 1);
    chk("R6 nak txAvail", txAvail, 1); chk("R6 nak txAcked", txAcked, 0);
    xmit(8'h24, 0);
    step(1, 0, 0, 0); step(0, 1, 0, 0);
    step(0, 0, 0, 1); outs("R6 noise", 0, 0, 1);
    chk("R6 noise txAvail", txAvail, 1);

    // R10 noise to enquiry
    xmit(8'h33, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1); outs("R10 noise", 0, 0, 0);
    chk("R10 txAvail", txAvail, 0); chk("R10 txAcked", txAcked, 0);
    repeat (WAIT + 2) begin
      step(0, 0, 0, 0);
      chk("R10 no token pass", passToken, 0);
    end
    step(1, 0, 0, 0); outs("R10 reissue", 1, 0, 0);

    // R13 cancel armed during the enquiry wait, applied at next token
    cmdDisable = 1; @(negedge clk); cmdDisable = 0;
    step(0, 0, 1, 0); outs("R13 refusal", 0, 0, 1);
    chk("R13 deferred", txAvail, 0);
    step(1, 0, 0, 0); outs("R13 cancel", 0, 0, 1);
    chk("R13 txAvail", txAvail, 1); chk("R13 txAcked", txAcked, 0);
    // R13 cancel ignored when idle
    cmdDisable = 1; @(negedge clk); cmdDisable = 0;
    xmit(8'h44, 0);
    step(1, 0, 0, 0); outs("R13 ignored", 1, 0, 0);
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    chk("R13 completes", txAcked, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule